// File: doc/BRIEF.md
# Repeating-Fraction Mantissa Adder

This block adds two fractional operands held in a two-part positional form. Each operand has a sign, a fixed part of `FW` binary digits that sits directly after the radix point, and a repeating part of 1 to `PW` digits that repeats without end after the fixed part. Both operands must already be aligned, so their fixed parts cover the same digit positions. The block gives back the exact sum in the same form. It also returns a single integer digit for the case where a same-sign sum reaches one or more.

The two repeating parts are first stretched to a common length, which is the least common multiple of their two lengths. That length is found over several cycles by stepping two running multiples toward each other. The stretched parts are then added with an end-around carry: a carry out of the repeating sum is added back into the repeating result and is also fed into the fixed sum. A subtraction adds the ones' complement of the smaller-signed operand. When the fixed carry shows the result is negative, the whole result string is complemented back. If the common length would exceed `PW`, each part is wrapped only up to `PW` digits and the result is marked approximate.

A caller pulses the start input with both operands present. Some cycles later, the done output pulses for one cycle and the result appears. The result stays on the outputs until the next operation finishes.

Top module: `rma_top`

## Requirements
- R1: After reset, `o_done`, `o_sign`, `o_int`, `o_approx`, `o_fix`, `o_per` and `o_plen` are all zero.
- R2: A repeating part of length L is held in bits [L-1:0], and bit L-1 is its first digit. Every result has `o_plen` equal to lcm(La, Lb) when that value is at most `PW`. The result's repeating part sits in bits [o_plen-1:0], and all higher bits are zero.
- R3: For operands of equal sign, the result value ((o_int·2^FW + o_fix)·(2^n−1) + o_per), where n = o_plen, equals |A + B| scaled the same way.
- R4: A carry out of the repeating sum adds one to the repeating result and one to the fixed sum.
- R5: For operands of opposite sign, the result magnitude is |A − B| exactly, `o_int` is 0, and equal magnitudes give a zero fixed part and a zero repeating part.
- R6: For equal signs, `o_sign` is the shared sign. For opposite signs, `o_sign` is the sign of the operand with the larger magnitude.
- R7: When lcm(La, Lb) > `PW`, `o_approx` is 1 and `o_plen` is `PW`. Each repeating part is then wrapped to `PW` digits, and the result is their exact sum. Otherwise `o_approx` is 0.
- R8: `o_done` is a one-cycle pulse for each accepted start. All result outputs hold their values between pulses.
- R9: A start that arrives while an operation is in progress is ignored. It produces no result and no extra done pulse.
- R10: For equal signs, `o_int` is 1 when the sum carries out of the top fixed digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Starts an operation when the block is idle |
| i_sign_a | input | 1 | Sign of A (1 = negative) |
| i_fix_a | input | FW | Fixed digits of A, first digit in the MSB |
| i_per_a | input | PW | Repeating digits of A in bits [La-1:0] |
| i_plen_a | input | LW | Repeating length of A (1..PW) |
| i_sign_b | input | 1 | Sign of B |
| i_fix_b | input | FW | Fixed digits of B |
| i_per_b | input | PW | Repeating digits of B |
| i_plen_b | input | LW | Repeating length of B (1..PW) |
| o_done | output | 1 | One-cycle completion pulse |
| o_sign | output | 1 | Result sign |
| o_int | output | 1 | Integer digit of the result |
| o_fix | output | FW | Result fixed digits |
| o_per | output | PW | Result repeating digits |
| o_plen | output | LW | Result repeating length |
| o_approx | output | 1 | Result repeating part was wrapped |

## Verification
The bench uses repeating parts of equal length, of coprime lengths and of lengths that share a factor. Together these separate a wrong common length from a wrong stretch order of the digits. One case forces a carry only out of the repeating sum, to show the end-around path into both parts. Opposite-sign pairs are run with each operand larger in turn and with equal magnitudes, so that both the complement-back selection and the sign choice are exercised. A large same-sign sum exercises the integer digit. A pair of coprime lengths whose product exceeds the capacity exercises the wrap path. Every result is compared by value against a rational model, so an unnormalised but equal digit string is still accepted.

// File: rtl/rma_pkg.sv
package rma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LCM  = 2'd1,
    ST_ADD  = 2'd2
  } rma_state_t;
endpackage

// File: rtl/rma_period_lcm.sv
// Iterative common length: two running multiples step toward each other.
module rma_period_lcm #(
  parameter int PW = 12,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len_a,
  input  logic [LW-1:0] len_b,
  output logic          fin,
  output logic          ovf,
  output logic [LW-1:0] len
);
  localparam int AW = LW + 1;
  localparam logic [AW-1:0] CAP = AW'(PW);

  logic [AW-1:0] acc_a, acc_b;
  logic [LW-1:0] step_a, step_b;
  logic          active;

  always_comb begin
    ovf = (acc_a > CAP) || (acc_b > CAP);
    fin = active && (ovf || (acc_a == acc_b));
    len = ovf ? LW'(PW) : acc_a[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a  <= '0;
      acc_b  <= '0;
      step_a <= '0;
      step_b <= '0;
      active <= 1'b0;
    end else if (load) begin
      acc_a  <= {1'b0, len_a};
      acc_b  <= {1'b0, len_b};
      step_a <= len_a;
      step_b <= len_b;
      active <= 1'b1;
    end else if (active) begin
      if (fin)                active <= 1'b0;
      else if (acc_a < acc_b) acc_a  <= acc_a + {1'b0, step_a};
      else                    acc_b  <= acc_b + {1'b0, step_b};
    end
  end
endmodule

// File: rtl/rma_per_add.sv
// Stretches both repeating parts to n digits and adds them.
module rma_per_add #(
  parameter int PW = 12,
  parameter int LW = 4
) (
  input  logic [PW-1:0] pa,
  input  logic [PW-1:0] pb,
  input  logic [LW-1:0] la,
  input  logic [LW-1:0] lb,
  input  logic [LW-1:0] n,
  input  logic          sub,
  output logic [PW-1:0] sum,
  output logic [PW-1:0] sum_p1,
  output logic          cry,
  output logic [PW-1:0] mask
);
  function automatic logic [PW-1:0] stretch(input logic [PW-1:0] p,
                                            input logic [LW-1:0] l,
                                            input logic [LW-1:0] w);
    logic [PW-1:0] r;
    int k;
    r = '0;
    k = int'(l) - 1;
    for (int j = 0; j < PW; j++) begin
      if (j < int'(w) && k >= 0) r[int'(w) - 1 - j] = p[k];
      k = (k <= 0) ? int'(l) - 1 : k - 1;
    end
    return r;
  endfunction

  logic [PW-1:0] ra, rb, rbx;
  logic [PW:0]   sw;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i < int'(n));
    ra     = stretch(pa, la, n);
    rb     = stretch(pb, lb, n);
    rbx    = sub ? (~rb & mask) : rb;
    sw     = {1'b0, ra} + {1'b0, rbx};
    cry    = sw[n];
    sum    = sw[PW-1:0] & mask;
    sum_p1 = (sum + {{(PW-1){1'b0}}, 1'b1}) & mask;
  end
endmodule

// File: rtl/rma_fix_add.sv
// Fixed-part sum with candidates sum and sum+1; carry includes cin.
module rma_fix_add #(
  parameter int FW = 8
) (
  input  logic [FW-1:0] fa,
  input  logic [FW-1:0] fb,
  input  logic          sub,
  input  logic          cin,
  output logic [FW-1:0] sum,
  output logic [FW-1:0] sum_p1,
  output logic          cry
);
  logic [FW-1:0] fbx;
  logic [FW:0]   w0, w1;

  always_comb begin
    fbx    = sub ? ~fb : fb;
    w0     = {1'b0, fa} + {1'b0, fbx};
    sum    = w0[FW-1:0];
    w1     = {1'b0, sum} + {{FW{1'b0}}, 1'b1};
    sum_p1 = w1[FW-1:0];
    cry    = w0[FW] | (cin & w1[FW]);
  end
endmodule

// File: rtl/rma_top.sv
module rma_top #(
  parameter int FW = 8,
  parameter int PW = 12,
  localparam int LW = $clog2(PW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  logic          i_sign_a,
  input  logic [FW-1:0] i_fix_a,
  input  logic [PW-1:0] i_per_a,
  input  logic [LW-1:0] i_plen_a,
  input  logic          i_sign_b,
  input  logic [FW-1:0] i_fix_b,
  input  logic [PW-1:0] i_per_b,
  input  logic [LW-1:0] i_plen_b,
  output logic          o_done,
  output logic          o_sign,
  output logic          o_int,
  output logic [FW-1:0] o_fix,
  output logic [PW-1:0] o_per,
  output logic [LW-1:0] o_plen,
  output logic          o_approx
);
  import rma_pkg::*;

  rma_state_t    st;
  logic          sa_r, sb_r, apx_r;
  logic [FW-1:0] fa_r, fb_r;
  logic [PW-1:0] pa_r, pb_r;
  logic [LW-1:0] la_r, lb_r, n_r;

  // named internal events
  logic          w_load, w_fin, w_ovf, w_mixed, w_cp, w_cf, w_neg;
  logic [LW-1:0] w_len;
  logic [PW-1:0] ps, ps_p1, pmask, p_corr, p_res;
  logic [FW-1:0] fs, fs_p1, f_corr, f_res;
  logic          s_res;

  assign w_load  = (st == ST_IDLE) && i_start;
  assign w_mixed = sa_r ^ sb_r;

  rma_period_lcm #(.PW(PW), .LW(LW)) u_lcm (
    .clk(clk), .rst_n(rst_n), .load(w_load),
    .len_a(i_plen_a), .len_b(i_plen_b),
    .fin(w_fin), .ovf(w_ovf), .len(w_len)
  );

  rma_per_add #(.PW(PW), .LW(LW)) u_per (
    .pa(pa_r), .pb(pb_r), .la(la_r), .lb(lb_r), .n(n_r), .sub(w_mixed),
    .sum(ps), .sum_p1(ps_p1), .cry(w_cp), .mask(pmask)
  );

  rma_fix_add #(.FW(FW)) u_fix (
    .fa(fa_r), .fb(fb_r), .sub(w_mixed), .cin(w_cp),
    .sum(fs), .sum_p1(fs_p1), .cry(w_cf)
  );

  // candidate selection: sum, sum+1, or complement of the corrected sum
  always_comb begin
    p_corr = w_cp ? ps_p1 : ps;
    f_corr = w_cp ? fs_p1 : fs;
    w_neg  = w_mixed & ~w_cf;
    p_res  = w_neg ? (~p_corr & pmask) : p_corr;
    f_res  = w_neg ? ~f_corr : f_corr;
    s_res  = w_mixed ? (w_cf ? sa_r : sb_r) : sa_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {sa_r, sb_r, apx_r} <= '0;
      {fa_r, fb_r} <= '0;
      {pa_r, pb_r} <= '0;
      {la_r, lb_r, n_r} <= '0;
      o_done <= 1'b0; o_sign <= 1'b0; o_int <= 1'b0; o_approx <= 1'b0;
      o_fix <= '0; o_per <= '0; o_plen <= '0;
    end else begin
      o_done <= 1'b0;
      unique case (st)
        ST_IDLE: if (i_start) begin
          sa_r <= i_sign_a; fa_r <= i_fix_a; pa_r <= i_per_a; la_r <= i_plen_a;
          sb_r <= i_sign_b; fb_r <= i_fix_b; pb_r <= i_per_b; lb_r <= i_plen_b;
          st   <= ST_LCM;
        end
        ST_LCM: if (w_fin) begin
          n_r   <= w_len;
          apx_r <= w_ovf;
          st    <= ST_ADD;
        end
        ST_ADD: begin
          o_sign   <= s_res;
          o_int    <= ~w_mixed & w_cf;
          o_fix    <= f_res;
          o_per    <= p_res;
          o_plen   <= n_r;
          o_approx <= apx_r;
          o_done   <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rma_chk.sv
module rma_chk #(
  parameter int FW = 8,
  parameter int PW = 12,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          approx,
  input logic          int_o,
  input logic          mixed,
  input logic [FW-1:0] fix,
  input logic [PW-1:0] per,
  input logic [LW-1:0] plen
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_PLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (plen != '0) && (int'(plen) <= PW)); // R2
  AST_PER_FITS: assert property (@(posedge clk) disable iff (!rst_n) done |-> ((per >> plen) == '0)); // R2
  AST_APPROX_CAP: assert property (@(posedge clk) disable iff (!rst_n) (done && approx) |-> (int'(plen) == PW)); // R7
  AST_MIXED_NO_INT: assert property (@(posedge clk) disable iff (!rst_n) (done && mixed) |-> !int_o); // R5
  AST_HOLD_FIX: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(fix)); // R8
  AST_HOLD_PER: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(per)); // R8
endmodule

bind rma_top rma_chk #(.FW(FW), .PW(PW), .LW(LW)) u_rma_chk (
  .clk(clk), .rst_n(rst_n), .done(o_done), .approx(o_approx), .int_o(o_int),
  .mixed(w_mixed), .fix(o_fix), .per(o_per), .plen(o_plen)
);

// File: tb/test_rma_top.sv
module test_rma_top;
  localparam int FW = 8;
  localparam int PW = 12;
  localparam int LW = 4;

  typedef struct packed {
    logic          s;
    logic [FW-1:0] f;
    logic [PW-1:0] p;
    logic [LW-1:0] l;
  } opnd_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  opnd_t oa, ob;
  logic          o_done, o_sign, o_int, o_approx;
  logic [FW-1:0] o_fix;
  logic [PW-1:0] o_per;
  logic [LW-1:0] o_plen;
  logic          c_sign, c_int, c_apx;
  logic [FW-1:0] c_fix;
  logic [PW-1:0] c_per;
  logic [LW-1:0] c_plen;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  rma_top #(.FW(FW), .PW(PW)) i_rma_top (
    .clk(clk), .rst_n(rst_n), .i_start(start),
    .i_sign_a(oa.s), .i_fix_a(oa.f), .i_per_a(oa.p), .i_plen_a(oa.l),
    .i_sign_b(ob.s), .i_fix_b(ob.f), .i_per_b(ob.p), .i_plen_b(ob.l),
    .o_done(o_done), .o_sign(o_sign), .o_int(o_int), .o_fix(o_fix),
    .o_per(o_per), .o_plen(o_plen), .o_approx(o_approx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic opnd_t mk(input bit s, input int f, input int p, input int l);
    opnd_t r;
    r.s = s; r.f = FW'(f); r.p = PW'(p); r.l = LW'(l);
    return r;
  endfunction

  function automatic int gcd_m(input int a, input int b);
    while (b != 0) begin
      int t;
      t = a % b; a = b; b = t;
    end
    return a;
  endfunction

  function automatic longint wrap_m(input logic [PW-1:0] p, input int l, input int n);
    longint r = 0;
    for (int i = 0; i < n; i++) r = (r << 1) | longint'(p[(l - 1) - (i % l)]);
    return r;
  endfunction

  task automatic wait_done();
    int w = 0;
    while (!o_done && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk(o_done, "R8", "done seen", longint'(o_done), 1);
    c_sign = o_sign; c_int = o_int; c_apx = o_approx;
    c_fix = o_fix; c_per = o_per; c_plen = o_plen;
  endtask

  task automatic run(input opnd_t a, input opnd_t b);
    @(negedge clk);
    oa = a; ob = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic expect_sum(input opnd_t a, input opnd_t b, input string req);
    int la = int'(a.l), lb = int'(b.l);
    int lc = (la / gcd_m(la, lb)) * lb;
    int n = (lc > PW) ? PW : lc;
    longint d = (longint'(1) << n) - 1;
    longint va = longint'(a.f) * d + wrap_m(a.p, la, n);
    longint vb = longint'(b.f) * d + wrap_m(b.p, lb, n);
    longint x = (a.s ? -va : va) + (b.s ? -vb : vb);
    longint m = (x < 0) ? -x : x;
    longint got = ((longint'(c_int) << FW) + longint'(c_fix)) * d + longint'(c_per);
    chk(got == m, req, "value", got, m);
    chk(int'(c_plen) == n, "R2", "period length", longint'(c_plen), longint'(n));
    chk(c_apx == (lc > PW), "R7", "approx flag", longint'(c_apx), longint'(lc > PW));
    if (m != 0) chk(c_sign == (x < 0), "R6", "sign", longint'(c_sign), longint'(x < 0));
  endtask

  task automatic t_reset();
    chk(o_done == 0 && o_sign == 0 && o_int == 0 && o_approx == 0, "R1", "flags",
        longint'({o_done, o_sign, o_int, o_approx}), 0);
    chk(o_fix == 0 && o_per == 0 && o_plen == 0, "R1", "data",
        longint'(o_fix) + longint'(o_per) + longint'(o_plen), 0);
  endtask

  task automatic t_same_lengths();
    opnd_t a = mk(0, 'h50, 'b01, 2), b = mk(0, 'h21, 'b011, 3);
    run(a, b); expect_sum(a, b, "R3");        // lcm 6, R2
    a = mk(0, 'h0A, 'b0110, 4); b = mk(0, 'h33, 'b10, 2);
    run(a, b); expect_sum(a, b, "R3");        // shared factor, lcm 4
  endtask

  task automatic t_end_around();
    opnd_t a = mk(0, 'h10, 'b10, 2), b = mk(0, 'h01, 'b11, 2);
    run(a, b);
    chk(c_per == 'b10, "R4", "periodic +1", longint'(c_per), 2);
    chk(c_fix == 'h12, "R4", "fixed +cin", longint'(c_fix), 'h12);
    expect_sum(a, b, "R4");
  endtask

  task automatic t_mixed();
    opnd_t a = mk(0, 'h80, 'b1, 1), b = mk(1, 'h30, 'b101, 3);
    run(a, b); expect_sum(a, b, "R5");        // A larger
    a = mk(0, 'h12, 'b01, 2); b = mk(1, 'h47, 'b0011, 4);
    run(a, b); expect_sum(a, b, "R5");        // B larger, sign from B (R6)
    chk(c_sign == 1, "R6", "larger negative", longint'(c_sign), 1);
    chk(c_int == 0, "R5", "no integer digit", longint'(c_int), 0);
    a = mk(1, 'h3C, 'b110, 3); b = mk(0, 'h3C, 'b110, 3);
    run(a, b);
    chk(c_fix == 0 && c_per == 0, "R5", "equal cancels",
        longint'(c_fix) + longint'(c_per), 0);
  endtask

  task automatic t_neg_same();
    opnd_t a = mk(1, 'h25, 'b10, 2), b = mk(1, 'h11, 'b1, 1);
    run(a, b); expect_sum(a, b, "R6");
    chk(c_sign == 1, "R6", "shared negative", longint'(c_sign), 1);
  endtask

  task automatic t_int();
    opnd_t a = mk(0, 'hC0, 'b01, 2), b = mk(0, 'h80, 'b001, 3);
    run(a, b);
    chk(c_int == 1, "R10", "integer digit", longint'(c_int), 1);
    expect_sum(a, b, "R10");
  endtask

  task automatic t_approx();
    opnd_t a = mk(0, 'h05, 'b10110, 5), b = mk(0, 'h09, 'b0101101, 7);
    run(a, b);
    chk(c_apx == 1, "R7", "flag set", longint'(c_apx), 1);
    chk(int'(c_plen) == PW, "R7", "length capped", longint'(c_plen), PW);
    expect_sum(a, b, "R7");
  endtask

  task automatic t_hold();
    opnd_t a = mk(0, 'h44, 'b1001, 4), b = mk(0, 'h02, 'b01, 2);
    run(a, b);
    for (int i = 0; i < 6; i++) @(negedge clk);
    chk(o_done == 0, "R8", "pulse ended", longint'(o_done), 0);
    chk(o_fix == c_fix && o_per == c_per, "R8", "result held",
        longint'(o_fix), longint'(c_fix));
  endtask

  task automatic t_busy();
    opnd_t a = mk(0, 'h31, 'b011, 3), b = mk(0, 'h07, 'b1010, 4);
    int extra = 0;
    @(negedge clk);
    oa = a; ob = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    oa = mk(1, 'hFF, 'b1, 1); ob = mk(0, 'h01, 'b1, 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    expect_sum(a, b, "R9");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (o_done) extra++;
    end
    chk(extra == 0, "R9", "no extra result", longint'(extra), 0);
  endtask

  initial begin
    oa = '0; ob = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same_lengths();
    t_end_around();
    t_mixed();
    t_neg_same();
    t_int();
    t_approx();
    t_hold();
    t_busy();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule